// File: doc/BRIEF.md
# Wide Up-Counting Timer with Period Reload

The block is a 64-bit up-counter made of two 32-bit halves. A period register sets the terminal count. A second register holds the period to use for the next cycle. Four run modes select between holding, counting once to the period, wrapping continuously, and wrapping while loading the next period. Each increment comes either from the internal clock or from a rising edge of an external clock input, which is synchronised into the internal domain.

Software uses one 32-bit register port: a write strobe, a read strobe, a 3-bit address, and write and read data buses. It can write and read the count, the period and the reload value, and it writes and reads back the control word. The count is 64 bits and the timer keeps running while it is read, so the read port can return both halves coherently. Reading the low half captures the live high half into a shadow register. A later read of the high half returns that shadow.

The register map follows. Address 0 is the count low half. Address 1 is the count high half. Addresses 2 and 3 are the period low and high halves. Addresses 4 and 5 are the reload low and high halves. Address 6 is the control word. Address 7 reads as zero. The control word has these bits:
- bit 0 releases the low half from reset.
- bit 1 releases the high half from reset.
- bits 3:2 hold the run mode: 0 hold, 1 once, 2 loop, 3 loop with reload.
- bit 4 selects the external clock.
- bit 5 selects coherent 64-bit reads.
- bit 8 reads back a done flag.

Top module: `wideTimer`

## Requirements
- R1: While control bit 0 or bit 1 is 0, the count is held at zero and writes to the count are ignored.
- R2: In mode 0 with both reset controls at 1, the count keeps its value.
- R3: In mode 1 the count rises by one per tick until it reaches the period. It then stops there, and done (bit 8 of address 6) reads 1 until the control word is written again.
- R4: In mode 2, a tick while the count is at or above the period returns it to zero. Every other tick adds one. A count written to the period value reads 0 one cycle later and 1 the cycle after that.
- R5: In mode 3 the count wraps as in mode 2, and at each wrap the period takes the reload value. A reload write takes effect at the first wrap after the clock edge on which it is written.
- R6: With count and period both zero, enabling mode 1 or mode 2 leaves the count at zero.
- R7: Done is cleared by any control-word write and by either reset control being 0.
- R8: With bit 5 set, a read of address 0 captures the current high half. Reads of address 1 then return that captured value even after the live high half has changed.
- R9: With bit 5 clear, address 1 returns the live high half.
- R10: With bit 4 set, each rising edge of the external clock produces exactly one tick. With no edges, the count does not move.
- R11: With the external clock selected, once a mode 1 stop has occurred, no tick counts until an external rising edge has been seen while in mode 0.
- R12: Address 6 reads back the six control bits as written. After reset, every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (drives shadow capture) |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from address |
| extClk | input | 1 | External count clock, asynchronous |

## Verification
A wrong count, period or mode decode shows up at the count read port in the cycle after the faulty clock edge. The stimulus samples the low half every cycle and compares it against a model of the wrap and reload rules, so such a fault is seen within one period. A shadow fault stays hidden until the high half is read after a carry. A fault in the external restart gate shows only as extra or missing counts after the following burst of external edges.

// File: rtl/wideTimerPkg.sv
package wideTimerPkg;

  localparam int unsigned REG_ADDR_W = 3;
  localparam int unsigned NUM_DATA_REGS = 6;

  localparam logic [REG_ADDR_W-1:0] ADDR_CNT_LO = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CNT_HI = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_PRD_LO = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_PRD_HI = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_REL_LO = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_REL_HI = 3'd5;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 3'd6;

  localparam int unsigned DONE_BIT = 8;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_ONCE   = 2'd1,
    MODE_LOOP   = 2'd2,
    MODE_RELOAD = 2'd3
  } runMode_e;

  // field order is the bit layout of the control word, MSB first
  typedef struct packed {
    logic     wideRead;
    logic     extSel;
    runMode_e mode;
    logic     runHi;
    logic     runLo;
  } ctrlReg_t;

  localparam int unsigned CTRL_W = $bits(ctrlReg_t);

  typedef struct packed {
    logic                     clr;
    logic                     inc;
    logic                     wrap;
    logic                     reload;
    logic                     capHi;
    logic [NUM_DATA_REGS-1:0] wrSel;
  } dpStrobe_t;

endpackage

// File: rtl/wideTimerCtrl.sv
module wideTimerCtrl
  import wideTimerPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [CTRL_W-1:0]     ctrlWrData,
  input  logic                  extClk,
  input  logic                  atPeriod,
  output dpStrobe_t             st,
  output ctrlReg_t              ctrlQ,
  output logic                  doneQ
);

  logic syncA, syncB, syncC;
  logic extEdge;
  logic extReady;
  logic active;
  logic ctrlWr;
  logic tickOk;
  logic stopEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= extClk;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign extEdge = syncB & ~syncC;
  assign active  = ctrlQ.runLo & ctrlQ.runHi;
  assign ctrlWr  = regWrEn && (regAddr == ADDR_CTRL);
  assign tickOk  = ctrlQ.extSel ? (extEdge & extReady) : 1'b1;
  assign stopEvt = active && (ctrlQ.mode == MODE_ONCE) && atPeriod && !doneQ;

  always_comb begin
    st       = '0;
    st.clr   = !active;
    st.capHi = regRdEn && (regAddr == ADDR_CNT_LO) && ctrlQ.wideRead;
    for (int i = 0; i < NUM_DATA_REGS; i++) begin
      st.wrSel[i] = regWrEn && (regAddr == REG_ADDR_W'(i));
    end
    if (active && tickOk) begin
      unique case (ctrlQ.mode)
        MODE_ONCE: st.inc = !atPeriod && !doneQ;
        MODE_LOOP: begin
          st.inc  = !atPeriod;
          st.wrap = atPeriod;
        end
        MODE_RELOAD: begin
          st.inc    = !atPeriod;
          st.wrap   = atPeriod;
          st.reload = atPeriod;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= ctrlReg_t'(ctrlWrData);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
    end else if (!active || ctrlWr) begin
      doneQ <= 1'b0;
    end else if (stopEvt) begin
      doneQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extReady <= 1'b1;
    end else if (!active) begin
      extReady <= 1'b1;
    end else if (stopEvt) begin
      extReady <= 1'b0;
    end else if ((ctrlQ.mode == MODE_OFF) && extEdge) begin
      extReady <= 1'b1;
    end
  end

  AST_STOPPED_NO_INC: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !st.inc); // R3
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> !doneQ); // R7
  AST_EXT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    extEdge |=> !extEdge); // R10
  AST_EXT_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.extSel && !extEdge) |-> !(st.inc || st.wrap)); // R10

endmodule

// File: rtl/wideTimerData.sv
module wideTimerData
  import wideTimerPkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           st,
  input  logic [HALF_W-1:0]   wrData,
  output logic [2*HALF_W-1:0] cnt,
  output logic [2*HALF_W-1:0] prd,
  output logic [2*HALF_W-1:0] rel,
  output logic [HALF_W-1:0]   shadowHi,
  output logic                atPeriod
);

  localparam int unsigned CNT_W      = 2 * HALF_W;
  localparam int unsigned NUM_HALVES = 2;

  logic cntWr;

  assign cntWr    = st.wrSel[0] | st.wrSel[1];
  assign atPeriod = (cnt >= prd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (st.clr) begin
      cnt <= '0;
    end else if (cntWr) begin
      if (st.wrSel[0]) cnt[HALF_W-1:0] <= wrData;
      if (st.wrSel[1]) cnt[CNT_W-1:HALF_W] <= wrData;
    end else if (st.wrap) begin
      cnt <= '0;
    end else if (st.inc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prd <= '0;
      rel <= '0;
    end else begin
      if (st.reload) prd <= rel;
      for (int h = 0; h < NUM_HALVES; h++) begin
        if (st.wrSel[2+h]) prd[h*HALF_W +: HALF_W] <= wrData;
        if (st.wrSel[4+h]) rel[h*HALF_W +: HALF_W] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowHi <= '0;
    end else if (st.capHi) begin
      shadowHi <= cnt[CNT_W-1:HALF_W];
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    st.clr |=> (cnt == '0)); // R1
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (!st.clr && !st.inc && !st.wrap && !cntWr) |=> $stable(cnt)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrap && !st.clr && !cntWr) |=> (cnt == '0)); // R4
  AST_RELOAD_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (st.reload && !st.wrSel[2] && !st.wrSel[3]) |=> (prd == $past(rel))); // R5
  AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    ((prd == '0) && (cnt == '0) && !cntWr && !st.reload) |=> (cnt == '0)); // R6
  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    st.capHi |=> (shadowHi == $past(cnt[CNT_W-1:HALF_W]))); // R8

endmodule

// File: rtl/wideTimer.sv
module wideTimer
  import wideTimerPkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [HALF_W-1:0]     regWrData,
  output logic [HALF_W-1:0]     regRdData,
  input  logic                  extClk
);

  localparam int unsigned CNT_W = 2 * HALF_W;

  dpStrobe_t          st;
  ctrlReg_t           ctrlQ;
  logic               doneQ;
  logic               atPeriod;
  logic [CNT_W-1:0]   cnt, prd, rel;
  logic [HALF_W-1:0]  shadowHi;

  wideTimerCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .ctrlWrData (regWrData[CTRL_W-1:0]),
    .extClk     (extClk),
    .atPeriod   (atPeriod),
    .st         (st),
    .ctrlQ      (ctrlQ),
    .doneQ      (doneQ)
  );

  wideTimerData #(.HALF_W(HALF_W)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .wrData   (regWrData),
    .cnt      (cnt),
    .prd      (prd),
    .rel      (rel),
    .shadowHi (shadowHi),
    .atPeriod (atPeriod)
  );

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CNT_LO: regRdData = cnt[HALF_W-1:0];
      ADDR_CNT_HI: regRdData = ctrlQ.wideRead ? shadowHi : cnt[CNT_W-1:HALF_W];
      ADDR_PRD_LO: regRdData = prd[HALF_W-1:0];
      ADDR_PRD_HI: regRdData = prd[CNT_W-1:HALF_W];
      ADDR_REL_LO: regRdData = rel[HALF_W-1:0];
      ADDR_REL_HI: regRdData = rel[CNT_W-1:HALF_W];
      ADDR_CTRL: begin
        regRdData[CTRL_W-1:0] = ctrlQ;
        regRdData[DONE_BIT]   = doneQ;
      end
      default: regRdData = '0;
    endcase
  end

endmodule

// File: tb/wideTimer_tb_top.sv
module wideTimer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        extClk = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wideTimer dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .extClk    (extClk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic extPulses(input int n);
    for (int k = 0; k < n; k++) begin
      extClk = 1'b1;
      repeat (3) @(negedge clk);
      extClk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  function automatic logic [31:0] nextCount(input logic [31:0] prev, input logic [31:0] p,
                                            input int mode);
    if (prev >= p) return (mode >= 2) ? 32'd0 : prev;
    return prev + 32'd1;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c1, prev, expV, mPrd, mRel, newRel;
    int mode, wrCyc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    peek(3'd0, d); check("R12 cntLo after reset", d, 0);
    peek(3'd6, d); check("R12 ctrl after reset", d, 0);
    wr(3'd6, 32'h2B); peek(3'd6, d); check("R12 ctrl readback", d, 32'h2B);

    // R1 only one half released: count held at zero, writes ignored
    wr(3'd6, 32'h0); wr(3'd2, 32'd100);
    wr(3'd6, 32'h9);
    repeat (10) @(negedge clk);
    peek(3'd0, d); check("R1 held in reset", d, 0);
    wr(3'd0, 32'd5); peek(3'd0, d); check("R1 count write ignored", d, 0);

    // R3 / R7 once mode
    wr(3'd6, 32'h0); wr(3'd2, 32'd7); wr(3'd3, 32'd0);
    wr(3'd6, 32'h7);
    repeat (20) @(negedge clk);
    peek(3'd0, d); check("R3 stops at period", d, 7);
    peek(3'd6, d); check("R3 done set", {31'd0, d[8]}, 1);
    wr(3'd6, 32'h7);
    regRdEn = 1'b1; regAddr = 3'd6; #1 d = regRdData; regRdEn = 1'b0;
    check("R7 done cleared by ctrl write", {31'd0, d[8]}, 0);
    @(negedge clk);
    wr(3'd6, 32'h3);
    repeat (10) @(negedge clk);
    peek(3'd0, d); check("R2 mode0 holds stopped count", d, 7);
    peek(3'd6, d); check("R7 done stays clear in mode0", {31'd0, d[8]}, 0);
    wr(3'd6, 32'h7); repeat (3) @(negedge clk);
    wr(3'd6, 32'h0); peek(3'd6, d); check("R7 done cleared by reset", {31'd0, d[8]}, 0);

    // R2 hold a running count
    wr(3'd2, 32'd1000); wr(3'd6, 32'hB);
    repeat (10) @(negedge clk);
    wr(3'd6, 32'h3);
    peek(3'd0, c1);
    repeat (10) @(negedge clk);
    peek(3'd0, d); check("R2 count stable in mode0", d, c1);

    // R4 directed wrap at period
    wr(3'd2, 32'h40); wr(3'd6, 32'hB);
    repeat (5) @(negedge clk);
    wr(3'd0, 32'h40);
    regRdEn = 1'b1; regAddr = 3'd0;
    #1 check("R4 written to period", regRdData, 32'h40);
    @(negedge clk); #1 check("R4 wraps to zero", regRdData, 0);
    @(negedge clk); #1 check("R4 counts after wrap", regRdData, 1);
    regRdEn = 1'b0;
    @(negedge clk);

    // R6 zero count and zero period
    wr(3'd6, 32'h0); wr(3'd2, 32'd0); wr(3'd3, 32'd0);
    wr(3'd6, 32'hB); repeat (10) @(negedge clk);
    peek(3'd0, d); check("R6 loop mode stays zero", d, 0);
    wr(3'd6, 32'h7); repeat (10) @(negedge clk);
    peek(3'd0, d); check("R6 once mode stays zero", d, 0);

    // R8 / R9 coherent high read
    wr(3'd6, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd6, 32'h2B);
    wr(3'd1, 32'd5); wr(3'd0, 32'hFFFF_FFF0);
    peek(3'd0, d);
    repeat (30) @(negedge clk);
    peek(3'd1, d); check("R8 shadow returned after carry", d, 5);
    wr(3'd6, 32'h0B);
    peek(3'd1, d); check("R9 live high half", d, 6);

    // R10 external clock
    wr(3'd6, 32'h0); wr(3'd3, 32'd0);
    wr(3'd6, 32'h1B);
    repeat (10) @(negedge clk);
    peek(3'd0, d); check("R10 no edges no count", d, 0);
    extPulses(5);
    peek(3'd0, d); check("R10 one tick per edge", d, 5);

    // R11 external restart rule
    wr(3'd6, 32'h0); wr(3'd2, 32'd3);
    wr(3'd6, 32'h17);
    extPulses(6);
    peek(3'd0, d); check("R11 once mode stops on ext", d, 3);
    wr(3'd2, 32'd10);
    wr(3'd6, 32'h17);
    extPulses(3);
    peek(3'd0, d); check("R11 no restart without idle edge", d, 3);
    wr(3'd6, 32'h13);
    extPulses(1);
    wr(3'd6, 32'h17);
    extPulses(3);
    peek(3'd0, d); check("R11 restart after idle edge", d, 6);

    // R3 R4 R5 random walks checked against the model
    for (int it = 0; it < 12; it++) begin
      mode   = 1 + int'($urandom % 3);
      mPrd   = $urandom % 16;
      mRel   = $urandom % 16;
      newRel = $urandom % 16;
      wrCyc  = int'($urandom % 50);
      wr(3'd6, 32'h0);
      wr(3'd2, mPrd); wr(3'd3, 32'd0); wr(3'd4, mRel); wr(3'd5, 32'd0);
      wr(3'd6, 32'h3 | (mode << 2));
      regRdEn = 1'b1; regAddr = 3'd0;
      #1 check("R4 walk start", regRdData, 0);
      prev = 0;
      for (int i = 0; i < 60; i++) begin
        if (i == wrCyc) begin
          regWrEn = 1'b1; regAddr = 3'd4; regWrData = newRel;
        end
        @(posedge clk);
        expV = nextCount(prev, mPrd, mode);
        if (mode == 3 && prev >= mPrd) mPrd = mRel;
        if (i == wrCyc) mRel = newRel;
        @(negedge clk);
        regWrEn = 1'b0; regAddr = 3'd0;
        #1 check(mode == 3 ? "R5 reload walk" : (mode == 2 ? "R4 loop walk" : "R3 once walk"),
                 regRdData, expV);
        prev = expV;
      end
      regRdEn = 1'b0;
      @(negedge clk);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule